// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a serial-bus master that fetches one conversion word from a low-power serial analog-to-digital converter that has no data input. A single-cycle start request drives the active-low select line low, which also wakes the converter, since a deselected converter sits in shutdown. The block then toggles a serial clock a fixed number of times at a rate set by a divider parameter, and samples the converter's data line on every falling clock edge, most significant bit first.

Each frame opens with six leading bits that carry no data, so the 16-bit word sits at a fixed offset inside the frame. The frame is 22 clocks long in its shortest form, or 24 clocks when the converter is read as three byte-sized transfers. Any bits that arrive after the 16 data bits are dropped. When the frame ends, the select line goes high, the busy flag drops, and a one-cycle done pulse comes out together with the new word. The word on the output changes only at that pulse.

Top module: `adc_frame_reader`

## Requirements
- R1: During reset and after it, cs_n is 1, sclk is 1, busy is 0, done is 0 and result is 0x0000.
- R2: A start that is sampled high while busy is low makes cs_n 0 and busy 1 in the next cycle.
- R3: sclk is high whenever the block is idle. Each frame has exactly FRAME_BITS falling edges of sclk, and the last edge of a frame is a rising edge.
- R4: sclk stays low for exactly HALF_CYC system cycles and high for exactly HALF_CYC system cycles between falling edges inside a frame. The default HALF_CYC of 53 at a 250 MHz system clock gives about 2.36 MHz, which is within the converter's 2.4 MHz limit.
- R5: cs_n falls exactly HALF_CYC cycles before the first sclk falling edge. It rises exactly HALF_CYC cycles after the last sclk rising edge.
- R6: Falling edges are numbered 0 upward. The bit sampled at edge 6 becomes result[15], and the bit sampled at edge 21 becomes result[0]. Bits sampled at edges 0..5 and at edges 22 and later have no effect on result.
- R7: A start that arrives while busy is high is ignored. The frame keeps its length and timing, and only one done pulse follows it.
- R8: done is high for exactly one cycle per frame. That cycle is the first cycle in which busy is 0 and cs_n is 1 again.
- R9: result changes only in the done cycle. During a frame it keeps the word from the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to read one conversion; acted on only while idle |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Converter select, active low; high puts the converter in shutdown |
| sclk | output | 1 | Serial clock to the converter; idles high |
| busy | output | 1 | High from select assertion until the frame closes |
| done | output | 1 | One-cycle pulse when a new word is on result |
| result | output | 16 | Last completed conversion word |

## Verification
The properties assume that start arrives as a pulse, that reset is synchronous, and that miso is already stable at each falling-edge sample. The converter model in the bench moves miso only on a rising sclk edge, half a period before the next sample, so this assumption holds. The bench shortens HALF_CYC to 4 to keep runs short. The same timing relations are checked against that parameter value.

// File: rtl/adc_rd_pkg.sv
// Shared types for the serial ADC frame reader.
package adc_rd_pkg;
    // Phases of one read frame
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,  // select high, converter in shutdown
        RD_LEAD  = 2'd1,  // select low, waiting before the first edge
        RD_SHIFT = 2'd2,  // serial clock toggling
        RD_TAIL  = 2'd3   // select still low, waiting after the last edge
    } rd_phase_t;
endpackage

// File: rtl/adc_rd_halfper.sv
// Half-period timer: while run is high, it raises tick once every
// HALF_CYC cycles. The count restarts from zero whenever run is low.
// Assumes HALF_CYC >= 2.
module adc_rd_halfper #(
    parameter int HALF_CYC = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_TOP);

    // Count the cycles of the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_seq.sv
// Frame sequencer: starts a frame from idle, holds select low for one
// half period before and after the clock burst, and emits FRAME_BITS
// falling edges. It marks each falling edge with sample_stb and the
// bit index of that edge, and marks the frame end with fin.
// Assumes tick comes from a half-period timer that is gated by run.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int FRAME_BITS = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          tick,
    output logic                          run,
    output logic                          cs_n,
    output logic                          sclk,
    output logic                          sample_stb,
    output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    output logic                          fin
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    rd_phase_t phase;

    assign run        = (phase != RD_IDLE);
    assign sample_stb = tick && ((phase == RD_LEAD) || (phase == RD_SHIFT && sclk));
    assign fin        = tick && (phase == RD_TAIL);

    // Move through the frame phases and drive select and clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= RD_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            bit_idx <= '0;
        end else begin
            case (phase)
                RD_IDLE: begin
                    if (start) begin
                        phase   <= RD_LEAD;
                        cs_n    <= 1'b0;
                        bit_idx <= '0;
                    end
                end
                RD_LEAD: begin
                    if (tick) begin
                        phase <= RD_SHIFT;
                        sclk  <= 1'b0;
                    end
                end
                RD_SHIFT: begin
                    if (tick) begin
                        if (sclk) begin
                            sclk <= 1'b0;
                        end else begin
                            sclk <= 1'b1;
                            if (bit_idx == LAST_IDX) begin
                                phase <= RD_TAIL;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                RD_TAIL: begin
                    if (tick) begin
                        phase <= RD_IDLE;
                        cs_n  <= 1'b1;
                    end
                end
                default: phase <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_rd_capture.sv
// Bit capture: shifts in only the bits whose index is in the data
// window, MSB first, and copies the assembled word to the output when
// the frame ends.
// Assumes miso is stable when sample_stb is high.
module adc_rd_capture #(
    parameter int FRAME_BITS = 24,
    parameter int LEAD_BITS  = 6,
    parameter int DATA_BITS  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample_stb,
    input  logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    input  logic                          miso,
    input  logic                          fin,
    output logic [DATA_BITS-1:0]          result,
    output logic                          done
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(LEAD_BITS);
    localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(LEAD_BITS + DATA_BITS - 1);

    logic [DATA_BITS-1:0] shreg;
    logic                 in_window;

    assign in_window = (bit_idx >= FIRST_IDX) && (bit_idx <= FINAL_IDX);

    // Shift data-window bits into the working register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sample_stb && in_window) begin
            shreg <= {shreg[DATA_BITS-2:0], miso};
        end
    end

    // Publish the whole word and pulse done at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                result <= shreg;
            end
        end
    end
endmodule

// File: rtl/adc_frame_reader.sv
// Serial ADC frame reader top: connects the half-period timer, the frame
// sequencer and the bit capture. One start pulse gives one 16-bit word.
// Assumes start is a pulse and that HALF_CYC keeps sclk within the
// converter's clock limit.
module adc_frame_reader #(
    parameter int HALF_CYC   = 53,
    parameter int FRAME_BITS = 24,
    parameter int LEAD_BITS  = 6,
    parameter int DATA_BITS  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 miso,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] result
);
    localparam int IDX_W = $clog2(FRAME_BITS);

    logic             run;
    logic             tick;
    logic             sample_stb;
    logic             fin;
    logic [IDX_W-1:0] bit_idx;

    assign busy = run;

    adc_rd_halfper #(.HALF_CYC(HALF_CYC)) u_halfper (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    adc_rd_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick      (tick),
        .run       (run),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sample_stb(sample_stb),
        .bit_idx   (bit_idx),
        .fin       (fin)
    );

    adc_rd_capture #(
        .FRAME_BITS(FRAME_BITS),
        .LEAD_BITS (LEAD_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .bit_idx   (bit_idx),
        .miso      (miso),
        .fin       (fin),
        .result    (result),
        .done      (done)
    );
endmodule

// File: rtl/adc_frame_reader_chk.sv
// Property checker for the serial ADC frame reader. It observes only the
// top-level ports and is attached to every instance by the bind below.
module adc_frame_reader_chk #(
    parameter int DATA_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 cs_n,
    input logic                 sclk,
    input logic                 busy,
    input logic                 done,
    input logic [DATA_BITS-1:0] result
);
    // R2: an idle start opens a frame on the next cycle
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !cs_n));

    // R3: the serial clock rests high outside a frame
    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    // R5: select is low exactly while the frame is running
    a_r5_cs_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);

    // R7: select only falls after an idle start, never mid-frame
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!busy && start));

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done marks the close of a frame
    a_r8_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n && $past(busy)));

    // R9: the output word changes only with done
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.DATA_BITS(DATA_BITS)) u_chk (.*);

// File: tb/tb_adc_frame_reader.sv
// Scoreboard bench for the serial ADC frame reader.
module tb_adc_frame_reader;
    localparam int HALF  = 4;
    localparam int FRAME = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        miso;
    logic        cs_n;
    logic        sclk;
    logic        busy;
    logic        done;
    logic [15:0] result;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] exp_q[$];
    logic [FRAME-1:0] fbits = '0;
    int rises = 0;
    logic [15:0] last_word = 16'h0000;

    always #2 clk = ~clk;

    adc_frame_reader #(.HALF_CYC(HALF), .FRAME_BITS(FRAME)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done), .result(result)
    );

    // Record one check and print a line if it failed
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: the next frame bit appears on each sclk rise
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) rises = 0;
        else      rises = rises + 1;
    end
    assign miso = (rises < FRAME) ? fbits[FRAME-1-rises] : 1'b0;

    // Monitor: edge timing, edge count, done pulse and scoreboard compare
    int  cyc = 0;
    int  last_evt = 0;
    int  falls = 0;
    bit  gap_bad = 0;
    bit  want_low = 0;
    logic p_cs = 1'b1;
    logic p_sclk = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_n != p_cs || sclk != p_sclk) begin
                if (!cs_n && p_cs) begin
                    falls = 0;
                    gap_bad = 0;
                end else if (cyc - last_evt != HALF) begin
                    gap_bad = 1;
                end
                if (!sclk && p_sclk) falls++;
                if (cs_n && !p_cs) begin
                    check(falls == FRAME, "R3 falling edges per frame", falls, FRAME);
                    check(!gap_bad, "R4/R5 half-period spacing of cs_n/sclk events", gap_bad, 0);
                    check(sclk == 1'b1, "R3 sclk high at frame end", sclk, 1);
                end
                last_evt = cyc;
            end
            if (want_low) begin
                check(done == 1'b0, "R8 done one cycle wide", done, 0);
                want_low = 0;
            end
            if (done) begin
                check(!busy && cs_n, "R8 done with busy low and cs_n high", {busy, cs_n}, 1);
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected extra done", 1, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(result == e, "R6 captured word", result, e);
                end
                want_low = 1;
            end
            p_cs = cs_n;
            p_sclk = sclk;
        end
    end

    // Driver: load the converter frame, push the expected word, run one read
    task automatic run_frame(input logic [15:0] d, input logic [5:0] lead,
                             input logic [1:0] tail, input bit poke);
        fbits = {lead, d, tail};
        exp_q.push_back(d);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!cs_n && busy, "R2 start opens frame", {cs_n, busy}, 1);
        repeat (HALF * 5) @(negedge clk);
        check(result == last_word, "R9 result held mid-frame", result, last_word);
        if (poke) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (2) @(negedge clk);
            check(busy && !cs_n, "R7 start ignored while busy", {busy, cs_n}, 2);
        end
        while (!done) @(negedge clk);
        last_word = d;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0h expected %0h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !busy && !done && result == 16'h0,
              "R1 state in reset", {cs_n, sclk, busy, done}, 4'b1100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !busy && !done && result == 16'h0,
              "R1 idle after reset", {cs_n, sclk, busy, done}, 4'b1100);

        run_frame(16'h0000, 6'h3F, 2'b11, 0);   // R6 leading and trailing ones dropped
        run_frame(16'hFFFF, 6'h00, 2'b00, 0);   // R6 leading and trailing zeros dropped
        run_frame(16'h8001, 6'h2A, 2'b10, 0);   // R6 end bits of the window
        run_frame(16'h1234, 6'h15, 2'b01, 1);   // R7 extra start mid-frame
        run_frame(16'hA5A5, 6'h3C, 2'b11, 0);
        for (int i = 0; i < 4; i++) begin
            run_frame(16'($urandom), 6'($urandom), 2'($urandom), i[0]);
        end

        repeat (HALF * 4) @(negedge clk);
        check(exp_q.size() == 0, "R6 every frame produced a word", exp_q.size(), 0);
        check(!busy && cs_n && sclk, "R3 idle after last frame", {busy, cs_n, sclk}, 3);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule